// File: doc/BRIEF.md
# Readout Capture Buffer with Register Readback

The block sits at the output of a readout formatter. It records the wide words that the formatter produces into a 1024-entry memory, so that software can inspect them later over a narrow 32-bit register bus. A single control bit arms the capture. While it is set, every input word marked valid is written at the current write pointer, and the pointer then steps forward, wrapping at the end of the memory.

Software reads a stored word by loading the read pointer and then reading eight 32-bit slice registers, with the least significant slice at the lowest address. The two pointer registers read back with a fixed 16-bit marker in their upper half, which lets software confirm that it is addressing the right block. Software can also load either pointer to replay a region or to restart capture at a chosen entry. The memory read is registered, so a slice read reflects a new read pointer one clock after the pointer has settled.

Top module: `cap_readout_buf`

## Requirements
- R1: After reset the write pointer is 0, the read pointer is 0 and capture is disabled. Register 8 reads 0xBEEF0000, register 9 reads 0xCAFE0000 and register 0xA reads 0.
- R2: While capture is enabled, each cycle with `cap_valid` high stores `cap_data` at the write pointer and increments the pointer. The increment wraps from 1023 to 0.
- R3: While capture is disabled, `cap_valid` has no effect. The write pointer keeps its value and no memory entry changes.
- R4: Register 8 reads as 0xBEEF in bits 31:16, zero in bits 15:10 and the write pointer in bits 9:0. A bus write to register 8 loads the write pointer from `bus_wdata[9:0]`. If a capture happens in the same cycle, the word is stored at the old pointer and the loaded value wins.
- R5: Register 9 reads as 0xCAFE in bits 31:16, zero in bits 15:10 and the read pointer in bits 9:0. A bus write to register 9 loads the read pointer from `bus_wdata[9:0]`.
- R6: Register 0xA holds the capture enable in bit 0. Bus writes take only `bus_wdata[0]`, and bits 31:1 read as zero.
- R7: Register k (k = 0..7) returns bits 32k+31 down to 32k of the entry selected by the read pointer. Bits at or above the data width (230 by default) read as zero. The value is valid from the second rising edge after the bus write that loaded the read pointer.
- R8: Bus writes to registers 0..7 and 0xB..0xF change no pointer, no enable and no stored entry. Reads of 0xB..0xF return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Input word qualifier |
| cap_data | input | DATA_W (230) | Readout word to capture |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational from state |

## Verification
Every cycle, the assertions check how the pointers and the enable move. They confirm the write pointer steps by one (modulo 1024) on an enabled capture, holds while capture is disabled, and takes the bus value on a pointer write. They also confirm that writes to the slice addresses leave the read pointer and the enable unchanged, and that the control and unmapped registers read zero where required. The actual contents of memory can be shown only by the bench's scenarios. These cover random captures read back slice by slice, the 1023-to-0 wrap, a capture that collides with a pointer load, the padding of the top slice, and disabled captures that must not overwrite an entry.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int REG_W      = 32;
    localparam int TAG_W      = 16;
    localparam int MAX_DATA_W = 256;
    localparam int N_SLICE    = MAX_DATA_W / REG_W;

    localparam logic [TAG_W-1:0] WPTR_TAG = 16'hBEEF;
    localparam logic [TAG_W-1:0] RPTR_TAG = 16'hCAFE;

    // register map; slices occupy 0..N_SLICE-1
    localparam logic [3:0] RA_WPTR = 4'h8;
    localparam logic [3:0] RA_RPTR = 4'h9;
    localparam logic [3:0] RA_CTRL = 4'hA;

    typedef struct packed {
        logic             wr;
        logic [3:0]       addr;
        logic [REG_W-1:0] data;
    } reg_req_t;

    function automatic logic [REG_W-1:0] tagged_ptr(input logic [TAG_W-1:0] tag,
                                                   input logic [TAG_W-1:0] ptr);
        return {tag, ptr};
    endfunction

    function automatic logic is_slice_addr(input logic [3:0] a);
        return a < 4'(N_SLICE);
    endfunction

    function automatic logic is_unmapped(input logic [3:0] a);
        return a > RA_CTRL;
    endfunction

endpackage

// File: rtl/cap_ctrl_regs.sv
module cap_ctrl_regs
    import cap_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              cap_valid,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              cap_en,
    output logic              mem_we
);

    logic ld_wptr, ld_rptr, ld_ctrl;

    always_comb begin
        ld_wptr = req.wr && (req.addr == RA_WPTR);
        ld_rptr = req.wr && (req.addr == RA_RPTR);
        ld_ctrl = req.wr && (req.addr == RA_CTRL);
        mem_we  = cap_en && cap_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cap_en <= 1'b0;
        end else begin
            if (ld_wptr)
                wr_ptr <= req.data[ADDR_W-1:0];
            else if (mem_we)
                wr_ptr <= wr_ptr + 1'b1;
            if (ld_rptr)
                rd_ptr <= req.data[ADDR_W-1:0];
            if (ld_ctrl)
                cap_en <= req.data[0];
        end
    end

    // R2: an enabled capture advances the pointer by one, modulo depth
    p_wptr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cap_valid && !ld_wptr) |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1));

    // R3: with capture off the write pointer only moves by a bus load
    p_wptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !ld_wptr) |=> $stable(wr_ptr));

    // R4: bus load of the write pointer wins over a capture
    p_wptr_load_r4: assert property (@(posedge clk) disable iff (rst)
        ld_wptr |=> wr_ptr == $past(req.data[ADDR_W-1:0]));

    // R5
    p_rptr_load_r5: assert property (@(posedge clk) disable iff (rst)
        ld_rptr |=> rd_ptr == $past(req.data[ADDR_W-1:0]));

    // R6
    p_ctrl_load_r6: assert property (@(posedge clk) disable iff (rst)
        ld_ctrl |=> cap_en == $past(req.data[0]));

    // R8: writes to read-only slices leave control state alone
    p_ro_write_r8: assert property (@(posedge clk) disable iff (rst)
        (req.wr && is_slice_addr(req.addr)) |=> ($stable(rd_ptr) && $stable(cap_en)));

endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int DATA_W = 230,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // read-first synchronous memory
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/cap_readback.sv
module cap_readback
    import cap_pkg::*;
#(
    parameter int DATA_W = 230,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] word,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic              cap_en,
    output logic [REG_W-1:0]  rdata
);

    localparam int PAD_W = MAX_DATA_W - DATA_W;

    logic [MAX_DATA_W-1:0] padded;
    logic [TAG_W-1:0]      wp_ext, rp_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign padded = {{PAD_W{1'b0}}, word};
        end else begin : g_nopad
            assign padded = word;
        end
        if (ADDR_W < TAG_W) begin : g_pext
            assign wp_ext = {{(TAG_W-ADDR_W){1'b0}}, wr_ptr};
            assign rp_ext = {{(TAG_W-ADDR_W){1'b0}}, rd_ptr};
        end else begin : g_pfull
            assign wp_ext = wr_ptr[TAG_W-1:0];
            assign rp_ext = rd_ptr[TAG_W-1:0];
        end
    endgenerate

    always_comb begin
        if (is_slice_addr(addr))
            rdata = padded[32'(addr[2:0]) * REG_W +: REG_W];
        else if (addr == RA_WPTR)
            rdata = tagged_ptr(WPTR_TAG, wp_ext);
        else if (addr == RA_RPTR)
            rdata = tagged_ptr(RPTR_TAG, rp_ext);
        else if (addr == RA_CTRL)
            rdata = {{(REG_W-1){1'b0}}, cap_en};
        else
            rdata = '0;
    end

    // R6: only the enable bit is visible in the control register
    p_ctrl_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_CTRL) |-> (rdata[REG_W-1:1] == '0 && rdata[0] == cap_en));

    // R8: unmapped reads are zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        is_unmapped(addr) |-> rdata == '0);

endmodule

// File: rtl/cap_readout_buf.sv
module cap_readout_buf
    import cap_pkg::*;
#(
    parameter int DATA_W = 230,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    reg_req_t          req;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic              cap_en, mem_we;
    logic [DATA_W-1:0] sel_word;

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    cap_ctrl_regs #(.ADDR_W(ADDR_W)) i_ctrl (
        .clk(clk), .rst(rst), .req(req), .cap_valid(cap_valid),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cap_en(cap_en), .mem_we(mem_we)
    );

    cap_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
        .clk(clk), .we(mem_we), .waddr(wr_ptr), .wdata(cap_data),
        .raddr(rd_ptr), .rdata(sel_word)
    );

    cap_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rdback (
        .clk(clk), .rst(rst), .addr(bus_addr), .word(sel_word),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cap_en(cap_en), .rdata(bus_rdata)
    );

    // R1: state leaving reset
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (wr_ptr == '0 && rd_ptr == '0 && !cap_en));

endmodule

// File: tb/test_cap_readout_buf.sv
module test_cap_readout_buf;

    localparam int DW    = 230;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cap_valid;
    logic [DW-1:0] cap_data;
    logic          bus_wr;
    logic [3:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_wp, m_rp;
    logic          m_en;

    always #10 clk = ~clk;

    cap_readout_buf #(.DATA_W(DW), .ADDR_W(AW)) i_cap_readout_buf (
        .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rand_word();
        logic [255:0] t;
        for (int k = 0; k < 8; k++) t[32*k +: 32] = $urandom;
        return t[DW-1:0];
    endfunction

    function automatic logic [31:0] exp_slice(input logic [DW-1:0] w, input int k);
        logic [255:0] p;
        p = '0;
        p[DW-1:0] = w;
        return p[32*k +: 32];
    endfunction

    // one clock: drive at negedge, update model at posedge, return at negedge
    task automatic tick(input bit wr, input logic [3:0] a, input logic [31:0] d,
                        input bit v, input logic [DW-1:0] w);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        cap_valid = v; cap_data = w;
        @(posedge clk);
        if (v && m_en) begin
            m_mem[m_wp] = w;
            m_wp = m_wp + 1'b1;
        end
        if (wr) begin
            if (a == 4'h8) m_wp = d[AW-1:0];
            if (a == 4'h9) m_rp = d[AW-1:0];
            if (a == 4'hA) m_en = d[0];
        end
        @(negedge clk);
        bus_wr = 1'b0; cap_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #2;
        v = bus_rdata;
    endtask

    task automatic chk_ptrs(input string tag);
        logic [31:0] v;
        rd(4'h8, v); chk({"R4 ", tag}, v, {16'hBEEF, 6'd0, m_wp});
        rd(4'h9, v); chk({"R5 ", tag}, v, {16'hCAFE, 6'd0, m_rp});
        rd(4'hA, v); chk({"R6 ", tag}, v, {31'd0, m_en});
    endtask

    // R7: load read pointer, wait one edge for the registered read, compare slices
    task automatic chk_entry(input logic [AW-1:0] e, input string tag);
        logic [31:0] v;
        tick(1, 4'h9, 32'(e), 0, '0);
        tick(0, 4'h0, 0, 0, '0);
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), v);
            chk({"R7 ", tag}, v, exp_slice(m_mem[e], k));
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0]   v;
        logic [DW-1:0] w;
        logic [AW-1:0] last;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; cap_valid = 0; cap_data = '0;
        bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        m_wp = '0; m_rp = '0; m_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd(4'h8, v); chk("R1 wptr", v, 32'hBEEF0000);
        rd(4'h9, v); chk("R1 rptr", v, 32'hCAFE0000);
        rd(4'hA, v); chk("R1 ctrl", v, 32'h0);

        // R6: only bit 0 taken
        tick(1, 4'hA, 32'hFFFF_FFFE, 0, '0);
        rd(4'hA, v); chk("R6 upper ignored", v, 32'h0);
        tick(1, 4'hA, 32'hFFFF_FFFF, 0, '0);
        rd(4'hA, v); chk("R6 set", v, 32'h1);

        // R2: random capture
        for (int i = 0; i < 60; i++)
            tick(0, 4'h0, 0, ($urandom % 10) < 7, rand_word());
        chk_ptrs("after random capture");
        tick(1, 4'hA, 32'h0, 0, '0);
        for (int e = 0; e < 6; e++) chk_entry(AW'(e), "random entry");
        last = m_wp - 1'b1;
        chk_entry(last, "last entry");

        // R3: disabled capture changes nothing
        tick(1, 4'h8, 32'd3, 0, '0);
        for (int i = 0; i < 8; i++) tick(0, 4'h0, 0, 1, rand_word());
        chk_ptrs("disabled");
        chk_entry(AW'(3), "R3 entry untouched");

        // R2: wrap 1023 -> 0
        tick(1, 4'h8, 32'd1022, 0, '0);
        tick(1, 4'hA, 32'd1, 0, '0);
        for (int i = 0; i < 3; i++) tick(0, 4'h0, 0, 1, rand_word());
        rd(4'h8, v); chk("R2 wrap ptr", v, {16'hBEEF, 6'd0, 10'd1});
        tick(1, 4'hA, 32'd0, 0, '0);
        chk_entry(AW'(1023), "wrap 1023");
        chk_entry(AW'(0), "wrap 0");

        // R4: pointer load collides with capture
        tick(1, 4'hA, 32'd1, 0, '0);
        tick(1, 4'h8, 32'h1234_5064, 1, rand_word());
        rd(4'h8, v); chk("R4 load wins", v, {16'hBEEF, 6'd0, 10'h064});
        tick(0, 4'h0, 0, 1, rand_word());
        tick(1, 4'hA, 32'd0, 0, '0);
        chk_entry(AW'(1), "R4 old ptr stored");
        chk_entry(AW'(100), "R4 new ptr stored");

        // R5: read pointer with upper data bits set
        tick(1, 4'h9, 32'hFFFF_FC07, 0, '0);
        rd(4'h9, v); chk("R5 load", v, {16'hCAFE, 6'd0, 10'h007});

        // R8: writes to slice and unmapped addresses are ignored
        chk_entry(AW'(2), "pre R8");
        tick(1, 4'h3, 32'hDEAD_BEEF, 0, '0);
        tick(1, 4'h0, 32'h0000_0155, 0, '0);
        tick(1, 4'hB, 32'hFFFF_FFFF, 0, '0);
        tick(1, 4'hF, 32'h0000_0003, 0, '0);
        chk_ptrs("R8 after ignored writes");
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), v);
            chk("R8 slices unchanged", v, exp_slice(m_mem[2], k));
        end
        for (int a = 11; a < 16; a++) begin
            rd(4'(a), v); chk("R8 unmapped read", v, 32'h0);
        end

        // R7: directed pad check on the top slice
        w = '1;
        tick(1, 4'h8, 32'd500, 0, '0);
        tick(1, 4'hA, 32'd1, 0, '0);
        tick(0, 4'h0, 0, 1, w);
        tick(1, 4'hA, 32'd0, 0, '0);
        chk_entry(AW'(500), "all ones pad");
        rd(4'h7, v); chk("R7 top slice pad", v, 32'h0000_003F);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule